// File: doc/BRIEF.md
# GPIO Bank with Per-Pin Interrupt Detection

This block is a 32-pin general purpose I/O bank behind a simple synchronous register port. Software chooses per pin whether the pin is driven from an output data register or left as an input. The output data register can be changed atomically, one bit at a time, through write-only set, clear and toggle aliases. The synchronized level of every pin can always be read back, whatever its direction.

Each pin has its own event detector. A two-bit trigger code selects low level, high level, rising edge or falling edge. A separate both-edges bit overrides that code. Detected events latch into a status register, which software clears by writing 1s. A mask register gates the status bits onto two interrupt lines: one covers pins 0 to 15 and the other covers pins 16 to 31. Pad electrical controls and pin muxing are handled elsewhere in the chip.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset, the output data, direction, mask, trigger and both-edges registers are all zero, and padOut, padOe, irqLow and irqHigh are 0.
- R2: Offset 0 holds the output data register and offset 1 holds the direction register. padOe equals the direction register, and padOut always equals the data register. The data value is kept while a pin is an input, so it appears again when the pin is switched back to output.
- R3: Writing to offset 8 sets, offset 9 clears, and offset 10 toggles every data bit whose written bit is 1. Written 0 bits leave the data unchanged. Reads of offsets 8 to 10 return 0.
- R4: Offset 2 returns padIn as seen through a two-flop synchronizer, for every pin whatever its direction. Writes to offset 2 have no effect.
- R5: Each pin has a trigger code: 00 is low level, 01 is high level, 10 is rising edge, 11 is falling edge. Pin n < 16 uses bits [2n+1:2n] of offset 3. Pin n >= 16 uses bits [2(n-16)+1:2(n-16)] of offset 4. Edges are found by comparing the synchronized level with its previous sample.
- R6: A 1 in bit n of offset 7 makes pin n detect both rising and falling edges, whatever its trigger code.
- R7: Status (offset 6) bits stay set until software writes a 1 to that bit. Written 0 bits have no effect.
- R8: When a detection and a clearing write reach the same bit in the same cycle, the bit stays set. A level trigger whose condition still holds sets the bit again at once.
- R9: Status bits are set whatever the mask (offset 5) holds.
- R10: irqLow is the OR of status AND mask over pins 0 to 15. irqHigh is the same over pins 16 to 31.
- R11: A status bit is set on the third rising clock edge after the padIn change that causes it, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busWr | input | 1 | Register write strobe |
| busAddr | input | ADDR_W | Register word offset |
| busWrData | input | NUM_PINS | Write data |
| busRdData | output | NUM_PINS | Read data, combinational from busAddr |
| padIn | input | NUM_PINS | Pin levels, asynchronous |
| padOut | output | NUM_PINS | Value to drive on the pins |
| padOe | output | NUM_PINS | Drive enable per pin |
| irqLow | output | 1 | Interrupt for pins 0 to 15 |
| irqHigh | output | 1 | Interrupt for pins 16 to 31 |

## Verification
Register writes take effect at the clock edge that samples busWr. Reads are combinational, so the bench drives the address at a falling edge and samples 1 ns later. A padIn change is visible at offset 2 after two rising edges and in the status register after three. Every stimulus step that moves a pad therefore waits three rising edges before the next falling-edge read. The latency test samples between the second and the third edge, and again after the third, to pin down R11 exactly. The same-cycle collision for R8 is set up by placing a clear write in the cycle in which an edge detection is pending.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  typedef enum logic [1:0] {
    TRIG_LOW  = 2'b00,
    TRIG_HIGH = 2'b01,
    TRIG_RISE = 2'b10,
    TRIG_FALL = 2'b11
  } trig_e;

  typedef enum logic [3:0] {
    REG_DATA    = 4'd0,
    REG_DIR     = 4'd1,
    REG_PADS    = 4'd2,
    REG_TRIG_LO = 4'd3,
    REG_TRIG_HI = 4'd4,
    REG_MASK    = 4'd5,
    REG_STATUS  = 4'd6,
    REG_BOTH    = 4'd7,
    REG_SET     = 4'd8,
    REG_CLR     = 4'd9,
    REG_TGL     = 4'd10
  } reg_e;

  localparam int unsigned REG_COUNT = 11;
  localparam int unsigned REG_IDX_W = 4;

  typedef struct packed {
    logic wrData;
    logic wrDir;
    logic wrTrigLo;
    logic wrTrigHi;
    logic wrMask;
    logic wrStatus;
    logic wrBoth;
    logic wrSet;
    logic wrClr;
    logic wrTgl;
  } strobe_t;

endpackage

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
  import gpio_bank_pkg::*;
#(
  parameter int unsigned ADDR_W = 4
) (
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  output strobe_t           strobes,
  output reg_e              rdSel,
  output logic              rdValid
);

  logic addrHit;
  reg_e addrIdx;

  assign addrHit = (busAddr < ADDR_W'(REG_COUNT));
  assign addrIdx = reg_e'(busAddr[REG_IDX_W-1:0]);
  assign rdSel   = addrIdx;
  assign rdValid = addrHit;

  always_comb begin
    strobes = '0;
    if (busWr && addrHit) begin
      case (addrIdx)
        REG_DATA:    strobes.wrData   = 1'b1;
        REG_DIR:     strobes.wrDir    = 1'b1;
        REG_TRIG_LO: strobes.wrTrigLo = 1'b1;
        REG_TRIG_HI: strobes.wrTrigHi = 1'b1;
        REG_MASK:    strobes.wrMask   = 1'b1;
        REG_STATUS:  strobes.wrStatus = 1'b1;
        REG_BOTH:    strobes.wrBoth   = 1'b1;
        REG_SET:     strobes.wrSet    = 1'b1;
        REG_CLR:     strobes.wrClr    = 1'b1;
        REG_TGL:     strobes.wrTgl    = 1'b1;
        default:     strobes = '0;
      endcase
    end
  end

endmodule

// File: rtl/gpio_pin_detect.sv
module gpio_pin_detect
  import gpio_bank_pkg::*;
(
  input  logic  clk,
  input  logic  rstN,
  input  logic  syncLvl,
  input  logic  prevLvl,
  input  trig_e trigCode,
  input  logic  bothEdge,
  input  logic  clrReq,
  output logic  statusBit
);

  logic hit;

  always_comb begin
    if (bothEdge) begin
      hit = syncLvl ^ prevLvl;
    end else begin
      case (trigCode)
        TRIG_LOW:  hit = ~syncLvl;
        TRIG_HIGH: hit = syncLvl;
        TRIG_RISE: hit = syncLvl & ~prevLvl;
        TRIG_FALL: hit = ~syncLvl & prevLvl;
        default:   hit = 1'b0;
      endcase
    end
  end

  // a new event wins over a simultaneous clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) statusBit <= 1'b0;
    else       statusBit <= (statusBit & ~clrReq) | hit;
  end

endmodule

// File: rtl/gpio_bank_datapath.sv
module gpio_bank_datapath
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NUM_PINS = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  strobe_t             strobes,
  input  reg_e                rdSel,
  input  logic                rdValid,
  input  logic [NUM_PINS-1:0] busWrData,
  output logic [NUM_PINS-1:0] busRdData,
  input  logic [NUM_PINS-1:0] padIn,
  output logic [NUM_PINS-1:0] padOut,
  output logic [NUM_PINS-1:0] padOe,
  output logic                irqLow,
  output logic                irqHigh,
  output logic [NUM_PINS-1:0] statusVec,
  output logic [NUM_PINS-1:0] maskVec
);

  localparam int unsigned HALF   = NUM_PINS / 2;
  localparam int unsigned TRIG_W = 2 * HALF;

  logic [NUM_PINS-1:0] dataQ, dirQ, maskQ, bothQ;
  logic [TRIG_W-1:0]   trigLoQ, trigHiQ;
  logic [NUM_PINS-1:0] sync1Q, sync2Q, prevQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataQ   <= '0;
      dirQ    <= '0;
      maskQ   <= '0;
      bothQ   <= '0;
      trigLoQ <= '0;
      trigHiQ <= '0;
    end else begin
      if (strobes.wrData)      dataQ <= busWrData;
      else if (strobes.wrSet)  dataQ <= dataQ | busWrData;
      else if (strobes.wrClr)  dataQ <= dataQ & ~busWrData;
      else if (strobes.wrTgl)  dataQ <= dataQ ^ busWrData;
      if (strobes.wrDir)    dirQ    <= busWrData;
      if (strobes.wrMask)   maskQ   <= busWrData;
      if (strobes.wrBoth)   bothQ   <= busWrData;
      if (strobes.wrTrigLo) trigLoQ <= busWrData[TRIG_W-1:0];
      if (strobes.wrTrigHi) trigHiQ <= busWrData[TRIG_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sync1Q <= '0;
      sync2Q <= '0;
      prevQ  <= '0;
    end else begin
      sync1Q <= padIn;
      sync2Q <= sync1Q;
      prevQ  <= sync2Q;
    end
  end

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    trig_e pinCode;
    if (i < HALF) begin : g_lo
      assign pinCode = trig_e'(trigLoQ[2*i +: 2]);
    end else begin : g_hi
      assign pinCode = trig_e'(trigHiQ[2*(i-HALF) +: 2]);
    end
    gpio_pin_detect i_detect (
      .clk      (clk),
      .rstN     (rstN),
      .syncLvl  (sync2Q[i]),
      .prevLvl  (prevQ[i]),
      .trigCode (pinCode),
      .bothEdge (bothQ[i]),
      .clrReq   (strobes.wrStatus & busWrData[i]),
      .statusBit(statusVec[i])
    );
  end

  always_comb begin
    busRdData = '0;
    if (rdValid) begin
      case (rdSel)
        REG_DATA:    busRdData = dataQ;
        REG_DIR:     busRdData = dirQ;
        REG_PADS:    busRdData = sync2Q;
        REG_TRIG_LO: busRdData[TRIG_W-1:0] = trigLoQ;
        REG_TRIG_HI: busRdData[TRIG_W-1:0] = trigHiQ;
        REG_MASK:    busRdData = maskQ;
        REG_STATUS:  busRdData = statusVec;
        REG_BOTH:    busRdData = bothQ;
        default:     busRdData = '0;
      endcase
    end
  end

  assign padOut  = dataQ;
  assign padOe   = dirQ;
  assign maskVec = maskQ;
  assign irqLow  = |(statusVec[HALF-1:0] & maskQ[HALF-1:0]);
  assign irqHigh = |(statusVec[NUM_PINS-1:HALF] & maskQ[NUM_PINS-1:HALF]);

endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NUM_PINS = 32,
  parameter int unsigned ADDR_W   = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                busWr,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic [NUM_PINS-1:0] busWrData,
  output logic [NUM_PINS-1:0] busRdData,
  input  logic [NUM_PINS-1:0] padIn,
  output logic [NUM_PINS-1:0] padOut,
  output logic [NUM_PINS-1:0] padOe,
  output logic                irqLow,
  output logic                irqHigh
);

  strobe_t             strobes;
  reg_e                rdSel;
  logic                rdValid;
  logic [NUM_PINS-1:0] statusVec;
  logic [NUM_PINS-1:0] maskVec;

  gpio_bank_ctrl #(.ADDR_W(ADDR_W)) i_ctrl (
    .busWr  (busWr),
    .busAddr(busAddr),
    .strobes(strobes),
    .rdSel  (rdSel),
    .rdValid(rdValid)
  );

  gpio_bank_datapath #(.NUM_PINS(NUM_PINS)) i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .rdSel    (rdSel),
    .rdValid  (rdValid),
    .busWrData(busWrData),
    .busRdData(busRdData),
    .padIn    (padIn),
    .padOut   (padOut),
    .padOe    (padOe),
    .irqLow   (irqLow),
    .irqHigh  (irqHigh),
    .statusVec(statusVec),
    .maskVec  (maskVec)
  );

endmodule

// File: rtl/gpio_irq_bank_chk.sv
module gpio_irq_bank_chk #(
  parameter int unsigned NUM_PINS = 32,
  parameter int unsigned ADDR_W   = 4
) (
  input logic                clk,
  input logic                rstN,
  input logic                busWr,
  input logic [ADDR_W-1:0]   busAddr,
  input logic [NUM_PINS-1:0] busWrData,
  input logic [NUM_PINS-1:0] busRdData,
  input logic [NUM_PINS-1:0] padOut,
  input logic [NUM_PINS-1:0] padOe,
  input logic                irqLow,
  input logic                irqHigh,
  input logic [NUM_PINS-1:0] statusVec,
  input logic [NUM_PINS-1:0] maskVec
);

  localparam int unsigned HALF = NUM_PINS / 2;

  logic                wrSetOp, wrClrOp, wrDirOp, wrStsOp;
  logic [NUM_PINS-1:0] clrBits;

  assign wrSetOp = busWr && (busAddr == ADDR_W'(8));
  assign wrClrOp = busWr && (busAddr == ADDR_W'(9));
  assign wrDirOp = busWr && (busAddr == ADDR_W'(1));
  assign wrStsOp = busWr && (busAddr == ADDR_W'(6));
  assign clrBits = wrStsOp ? busWrData : '0;

  AST_DIR_TO_OE: assert property (@(posedge clk) disable iff (!rstN)
    wrDirOp |=> (padOe == $past(busWrData))); // R2

  AST_SET_ALIAS: assert property (@(posedge clk) disable iff (!rstN)
    wrSetOp |=> ((padOut & $past(busWrData)) == $past(busWrData))); // R3

  AST_CLR_ALIAS: assert property (@(posedge clk) disable iff (!rstN)
    wrClrOp |=> ((padOut & $past(busWrData)) == '0)); // R3

  AST_ALIAS_READ_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr >= ADDR_W'(8) && busAddr <= ADDR_W'(10)) |-> (busRdData == '0)); // R3

  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((($past(statusVec) & ~$past(clrBits)) & ~statusVec) == '0)); // R7

  AST_IRQ_LOW_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
    irqLow |-> ((statusVec[HALF-1:0] & maskVec[HALF-1:0]) != '0)); // R10

  AST_IRQ_HIGH_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
    irqHigh |-> ((statusVec[NUM_PINS-1:HALF] & maskVec[NUM_PINS-1:HALF]) != '0)); // R10

  AST_NO_MASK_NO_IRQ: assert property (@(posedge clk) disable iff (!rstN)
    (maskVec == '0) |-> (!irqLow && !irqHigh)); // R9

endmodule

bind gpio_irq_bank gpio_irq_bank_chk #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) i_chk (
  .clk      (clk),
  .rstN     (rstN),
  .busWr    (busWr),
  .busAddr  (busAddr),
  .busWrData(busWrData),
  .busRdData(busRdData),
  .padOut   (padOut),
  .padOe    (padOe),
  .irqLow   (irqLow),
  .irqHigh  (irqHigh),
  .statusVec(statusVec),
  .maskVec  (maskVec)
);

// File: tb/test_gpio_irq_bank.sv
`timescale 1ns/100ps
module test_gpio_irq_bank;

  localparam int unsigned NP = 32;
  localparam int unsigned AW = 4;
  // kind: 0 write, 1 read-compare, 2 set pads and wait three edges, 3 irq compare {irqHigh, irqLow}
  localparam int unsigned NVEC = 53;
  localparam logic [41:0] VEC [NVEC] = '{
    {2'd1, 4'd0,  32'h0000_0000, 4'd1},  // R1
    {2'd1, 4'd1,  32'h0000_0000, 4'd1},  // R1
    {2'd1, 4'd5,  32'h0000_0000, 4'd1},  // R1
    {2'd1, 4'd6,  32'hFFFF_FFFF, 4'd5},  // R5 default low-level code
    {2'd3, 4'd0,  32'h0000_0000, 4'd1},  // R1
    {2'd0, 4'd0,  32'hA5A5_0F0F, 4'd2},  // R2
    {2'd1, 4'd0,  32'hA5A5_0F0F, 4'd2},  // R2
    {2'd0, 4'd8,  32'h0000_00F0, 4'd3},  // R3
    {2'd1, 4'd0,  32'hA5A5_0FFF, 4'd3},  // R3
    {2'd0, 4'd9,  32'hA500_0000, 4'd3},  // R3
    {2'd1, 4'd0,  32'h00A5_0FFF, 4'd3},  // R3
    {2'd0, 4'd10, 32'h0000_FFFF, 4'd3},  // R3
    {2'd1, 4'd0,  32'h00A5_F000, 4'd3},  // R3
    {2'd1, 4'd8,  32'h0000_0000, 4'd3},  // R3
    {2'd0, 4'd1,  32'hFFFF_0000, 4'd2},  // R2
    {2'd1, 4'd1,  32'hFFFF_0000, 4'd2},  // R2
    {2'd2, 4'd0,  32'h1234_5678, 4'd4},  // R4
    {2'd1, 4'd2,  32'h1234_5678, 4'd4},  // R4
    {2'd0, 4'd2,  32'hFFFF_FFFF, 4'd4},  // R4
    {2'd1, 4'd2,  32'h1234_5678, 4'd4},  // R4
    {2'd2, 4'd0,  32'h0000_0000, 4'd5},  // R5
    {2'd0, 4'd3,  32'h5555_5539, 4'd5},  // R5
    {2'd0, 4'd4,  32'h5555_5556, 4'd5},  // R5
    {2'd1, 4'd3,  32'h5555_5539, 4'd5},  // R5
    {2'd0, 4'd6,  32'hFFFF_FFFF, 4'd7},  // R7
    {2'd1, 4'd6,  32'h0000_0008, 4'd8},  // R8 low level re-sets
    {2'd2, 4'd0,  32'h0000_0003, 4'd5},  // R5
    {2'd1, 4'd6,  32'h0000_000B, 4'd5},  // R5
    {2'd3, 4'd0,  32'h0000_0000, 4'd9},  // R9
    {2'd0, 4'd5,  32'h0000_0002, 4'd10}, // R10
    {2'd3, 4'd0,  32'h0000_0001, 4'd10}, // R10
    {2'd0, 4'd6,  32'h0000_0002, 4'd7},  // R7
    {2'd1, 4'd6,  32'h0000_0009, 4'd7},  // R7
    {2'd3, 4'd0,  32'h0000_0000, 4'd10}, // R10
    {2'd2, 4'd0,  32'h0000_0001, 4'd5},  // R5
    {2'd1, 4'd6,  32'h0000_0009, 4'd5},  // R5 rising ignores fall
    {2'd0, 4'd7,  32'h0000_0002, 4'd6},  // R6
    {2'd2, 4'd0,  32'h0000_0003, 4'd6},  // R6
    {2'd1, 4'd6,  32'h0000_000B, 4'd6},  // R6
    {2'd0, 4'd6,  32'h0000_0002, 4'd7},  // R7
    {2'd1, 4'd6,  32'h0000_0009, 4'd7},  // R7
    {2'd2, 4'd0,  32'h0000_0001, 4'd6},  // R6
    {2'd1, 4'd6,  32'h0000_000B, 4'd6},  // R6 falling edge caught
    {2'd2, 4'd0,  32'h0000_0005, 4'd5},  // R5
    {2'd1, 4'd6,  32'h0000_000B, 4'd5},  // R5 falling ignores rise
    {2'd2, 4'd0,  32'h0000_0001, 4'd5},  // R5
    {2'd1, 4'd6,  32'h0000_000F, 4'd5},  // R5
    {2'd2, 4'd0,  32'h0001_0001, 4'd5},  // R5
    {2'd1, 4'd6,  32'h0001_000F, 4'd5},  // R5 upper word
    {2'd0, 4'd5,  32'h0001_0000, 4'd10}, // R10
    {2'd3, 4'd0,  32'h0000_0002, 4'd10}, // R10
    {2'd0, 4'd6,  32'h0000_0000, 4'd7},  // R7
    {2'd1, 4'd6,  32'h0001_000F, 4'd7}   // R7
  };

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          busWr = 1'b0;
  logic [AW-1:0] busAddr = '0;
  logic [NP-1:0] busWrData = '0;
  logic [NP-1:0] busRdData;
  logic [NP-1:0] padIn = '0;
  logic [NP-1:0] padOut, padOe;
  logic          irqLow, irqHigh;

  int checkCnt = 0;
  int failCnt  = 0;
  bit done     = 1'b0;

  always #2 clk = ~clk;

  gpio_irq_bank #(.NUM_PINS(NP), .ADDR_W(AW)) i_gpio_irq_bank (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData), .padIn(padIn),
    .padOut(padOut), .padOe(padOe), .irqLow(irqLow), .irqHigh(irqHigh)
  );

  task automatic check(input string req, input logic [NP-1:0] got, input logic [NP-1:0] exp);
    checkCnt++;
    if (got !== exp) begin
      failCnt++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic busWrite(input logic [AW-1:0] a, input logic [NP-1:0] d);
    @(negedge clk);
    busWr = 1'b1; busAddr = a; busWrData = d;
    @(negedge clk);
    busWr = 1'b0; busWrData = '0;
  endtask

  task automatic busRead(input logic [AW-1:0] a, output logic [NP-1:0] d);
    @(negedge clk);
    busAddr = a;
    #1;
    d = busRdData;
  endtask

  task automatic setPads(input logic [NP-1:0] v);
    @(negedge clk);
    padIn = v;
    repeat (3) @(posedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failCnt++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
      $finish;
    end
  end

  initial begin
    logic [NP-1:0] rd;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    check("R1 outputs", {padOut[15:0], padOe[15:0]}, '0);
    check("R1 irq", {30'd0, irqHigh, irqLow}, '0);
    @(posedge clk);

    for (int k = 0; k < NVEC; k++) begin
      logic [1:0]    kind;
      logic [3:0]    adr;
      logic [31:0]   dat;
      logic [3:0]    req;
      {kind, adr, dat, req} = VEC[k];
      case (kind)
        2'd0: busWrite(AW'(adr), dat);
        2'd1: begin
          busRead(AW'(adr), rd);
          check($sformatf("R%0d vec %0d", req, k), rd, dat);
        end
        2'd2: setPads(dat);
        default: begin
          @(negedge clk); #1;
          check($sformatf("R%0d vec %0d irq", req, k), {30'd0, irqHigh, irqLow}, dat);
        end
      endcase
    end

    // R2: pins reflect data/direction; data survives an input phase
    @(negedge clk); #1;
    check("R2 padOut", padOut, 32'h00A5_F000);
    check("R2 padOe", padOe, 32'hFFFF_0000);
    busWrite(AW'(1), 32'h0000_0000);
    #1;
    check("R2 input phase oe", padOe, 32'h0);
    busWrite(AW'(1), 32'hFFFF_FFFF);
    #1;
    check("R2 data retained", padOut, 32'h00A5_F000);

    // R11: status latency of three edges
    busWrite(AW'(6), 32'h0001_0000);
    busRead(AW'(6), rd);
    check("R7 clear bit16", rd, 32'h0000_000F);
    setPads(32'h0000_0000);
    busWrite(AW'(6), 32'h0000_000F);
    @(negedge clk);
    padIn = 32'h0001_0000;
    repeat (2) @(posedge clk);
    busRead(AW'(6), rd);
    check("R11 not yet after two edges", rd & 32'h0001_0000, 32'h0);
    @(posedge clk);
    busRead(AW'(6), rd);
    check("R11 set after third edge", rd & 32'h0001_0000, 32'h0001_0000);

    // R8: event and clear collide on pin1 (both edges)
    busWrite(AW'(6), 32'h0000_0002);
    busRead(AW'(6), rd);
    check("R7 pin1 cleared", rd & 32'h2, 32'h0);
    @(negedge clk);
    padIn = 32'h0001_0002;
    repeat (2) @(posedge clk);
    busWrite(AW'(6), 32'h0000_0002);
    busRead(AW'(6), rd);
    check("R8 set wins over clear", rd & 32'h2, 32'h2);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
    $finish;
  end

endmodule